// File: doc/BRIEF.md
# Dual-Issue Pairing and Pipe Steering

This block sits between the decode queue and the execution pipes of an in-order dual-issue core. Each cycle it looks at the two oldest decoded instructions, each carrying a 4-bit operation class, and decides whether none, the older one, or both may leave the queue. Every instruction that issues is sent to exactly one destination: integer pipe A, integer pipe B, the floating-point unit or the memory port.

The decision combines three things. The first is which class pairings are legal. The second is the per-cycle exclusive resources: pipe A holds its adder, address generator and shifter as one port; pipe B holds its adder, branch unit and multiply/divide as one port; the FP unit takes one operation per cycle; the memory port takes one access per cycle. The third is a busy vector from an external scoreboard for the multi-cycle units.

The block does not track register dependencies or latencies. The fetch queue advances by `issue_count`. With the default `REG_OUT = 1`, every output is registered once, so it reflects the inputs presented one clock earlier.

Top module: `duo_issue_steer`

## Requirements
- R1: A valid older instruction (slot 0) whose unit is not busy always issues, and `issue_count` is then at least 1.
- R2: Class codes and their destinations are fixed, with destination one-hot bit 0 = pipe A, bit 1 = pipe B, bit 2 = FP, bit 3 = memory. Code 1 shift → A. Codes 2/3 integer load/store → memory, also using pipe A. Codes 4/5 FP load/store → memory, also using pipe A. Code 6 integer↔FP register move → A. Code 7 multiply/divide → B. Code 8 branch → B. Codes 9/10/11 FP add-class/multiply/divide → FP. Codes 12 to 15 are the issue-alone classes and go to A.
- R3: Code 0, the simple integer op, may use pipe A or pipe B. In slot 0 it takes B when slot 1 is valid and its class needs pipe A, and takes A otherwise. In slot 1 it takes whichever of A and B slot 0 left free, A first.
- R4: Only these group pairings dual-issue, in either order: integer+integer, integer+FP arithmetic, and FP arithmetic+FP load/store. Integer includes codes 0 to 3 and 6 to 8.
- R5: At most one instruction per cycle uses each of pipe A, pipe B, the FP unit and the memory port. A pair that would share any of them issues only slot 0.
- R6: A branch in slot 0 ends the group, so slot 1 does not issue. A branch in slot 1 may issue with slot 0.
- R7: Codes 12 to 15 never issue together with another instruction, whichever slot they occupy.
- R8: Issue is in order. Slot 1 never issues unless slot 0 issues, and an invalid slot 0 gives `issue_count` = 0.
- R9: `unit_busy` bits block issue of an instruction, and of any younger one behind it. Bit 0 blocks multiply/divide. Bit 1 blocks FP multiply. Bit 2 blocks FP divide. Bit 3 blocks all loads and stores.
- R10: `issue_count` equals the number of issue bits set. A slot's pipe select is one-hot when it issues and zero when it does not. Outputs appear one clock after their inputs.
- R11: A synchronous active-low reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in0_valid | input | 1 | Slot 0 (older) instruction present |
| in0_class | input | 4 | Slot 0 operation class |
| in1_valid | input | 1 | Slot 1 (younger) instruction present |
| in1_class | input | 4 | Slot 1 operation class |
| unit_busy | input | 4 | Busy flags: mul/div, FP mul, FP div, memory port |
| issue0 | output | 1 | Slot 0 issued |
| issue1 | output | 1 | Slot 1 issued |
| pipe0_sel | output | 4 | Slot 0 destination, one-hot |
| pipe1_sel | output | 4 | Slot 1 destination, one-hot |
| issue_count | output | 2 | Instructions consumed this cycle |

## Verification
The bench targets the simple integer op steering around a younger shift, load or register move. A design that steers poorly there puts both instructions on pipe A or loses a pair that could have issued. It also drives branches in each slot, since a design that ignored group ending would issue past a branch. Issue-alone codes go in slot 1 as well as slot 0, to catch a check made only on the older slot. Busy flags are set behind a free older instruction, and in front of one, to catch out-of-order issue. Integer+FP-memory pairs are included because their resources do not collide, so only the group rule rejects them.

// File: rtl/duo_pkg.sv
// Package: shared constants and types for the dual-issue steering block.
// Assumes a 4-bit class code and four destinations encoded one-hot.
package duo_pkg;
    localparam int CLS_W  = 4;
    localparam int NPIPE  = 4;
    localparam int NBUSY  = 4;
    localparam int NSLOT  = 2;
    localparam int CNT_W  = $clog2(NSLOT + 1);

    // destination bit positions
    localparam int P_A   = 0;
    localparam int P_B   = 1;
    localparam int P_FP  = 2;
    localparam int P_MEM = 3;

    // busy bit positions
    localparam int BZ_MD   = 0;
    localparam int BZ_FMUL = 1;
    localparam int BZ_FDIV = 2;
    localparam int BZ_MEM  = 3;

    // class codes
    localparam logic [CLS_W-1:0] C_ALU    = 4'd0;
    localparam logic [CLS_W-1:0] C_SHIFT  = 4'd1;
    localparam logic [CLS_W-1:0] C_LOAD   = 4'd2;
    localparam logic [CLS_W-1:0] C_STORE  = 4'd3;
    localparam logic [CLS_W-1:0] C_FLOAD  = 4'd4;
    localparam logic [CLS_W-1:0] C_FSTORE = 4'd5;
    localparam logic [CLS_W-1:0] C_XFER   = 4'd6;
    localparam logic [CLS_W-1:0] C_MULDIV = 4'd7;
    localparam logic [CLS_W-1:0] C_BRANCH = 4'd8;
    localparam logic [CLS_W-1:0] C_FADD   = 4'd9;
    localparam logic [CLS_W-1:0] C_FMUL   = 4'd10;
    localparam logic [CLS_W-1:0] C_FDIV   = 4'd11;

    typedef enum logic [1:0] {
        GRP_INT  = 2'd0,
        GRP_FP   = 2'd1,
        GRP_FMEM = 2'd2,
        GRP_SOLO = 2'd3
    } grp_e;

    typedef struct packed {
        grp_e             grp;
        logic             flex;      // may use pipe A or pipe B
        logic [NPIPE-1:0] fixed;     // resources always claimed
        logic [NPIPE-1:0] route;     // destination when not flexible
        logic             busy_hit;  // its unit is busy this cycle
        logic             branch;    // ends the issue group
    } slot_dec_t;
endpackage

// File: rtl/duo_slot_decode.sv
// Module: decodes one slot's class into group, resource claim, destination
// and busy blocking. Purely combinational; unlisted codes are issue-alone.
module duo_slot_decode
    import duo_pkg::*;
(
    input  logic [CLS_W-1:0] cls,
    input  logic [NBUSY-1:0] busy,
    output slot_dec_t        dec
);
    localparam logic [NPIPE-1:0] M_A   = NPIPE'(1) << P_A;
    localparam logic [NPIPE-1:0] M_B   = NPIPE'(1) << P_B;
    localparam logic [NPIPE-1:0] M_FP  = NPIPE'(1) << P_FP;
    localparam logic [NPIPE-1:0] M_MEM = NPIPE'(1) << P_MEM;

    // Class lookup: one row per code, default covers the issue-alone codes.
    always_comb begin
        dec          = '0;
        dec.grp      = GRP_INT;
        case (cls)
            C_ALU:    dec.flex = 1'b1;
            C_SHIFT,
            C_XFER: begin
                dec.fixed = M_A;
                dec.route = M_A;
            end
            C_LOAD,
            C_STORE: begin
                dec.fixed    = M_A | M_MEM;
                dec.route    = M_MEM;
                dec.busy_hit = busy[BZ_MEM];
            end
            C_FLOAD,
            C_FSTORE: begin
                dec.grp      = GRP_FMEM;
                dec.fixed    = M_A | M_MEM;
                dec.route    = M_MEM;
                dec.busy_hit = busy[BZ_MEM];
            end
            C_MULDIV: begin
                dec.fixed    = M_B;
                dec.route    = M_B;
                dec.busy_hit = busy[BZ_MD];
            end
            C_BRANCH: begin
                dec.fixed  = M_B;
                dec.route  = M_B;
                dec.branch = 1'b1;
            end
            C_FADD: begin
                dec.grp   = GRP_FP;
                dec.fixed = M_FP;
                dec.route = M_FP;
            end
            C_FMUL: begin
                dec.grp      = GRP_FP;
                dec.fixed    = M_FP;
                dec.route    = M_FP;
                dec.busy_hit = busy[BZ_FMUL];
            end
            C_FDIV: begin
                dec.grp      = GRP_FP;
                dec.fixed    = M_FP;
                dec.route    = M_FP;
                dec.busy_hit = busy[BZ_FDIV];
            end
            default: begin
                dec.grp   = GRP_SOLO;
                dec.fixed = '1;
                dec.route = M_A;
            end
        endcase
    end
endmodule

// File: rtl/duo_pair_rule.sv
// Module: legality of a pairing by group, independent of order.
// Assumes the issue-alone group never pairs.
module duo_pair_rule
    import duo_pkg::*;
(
    input  grp_e grp0,
    input  grp_e grp1,
    output logic pair_ok
);
    // Group table: int+int, int+fp, fp+fp-memory, in either order.
    always_comb begin
        unique case ({grp0, grp1})
            {GRP_INT,  GRP_INT},
            {GRP_INT,  GRP_FP},
            {GRP_FP,   GRP_INT},
            {GRP_FP,   GRP_FMEM},
            {GRP_FMEM, GRP_FP}:   pair_ok = 1'b1;
            default:              pair_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/duo_steer.sv
// Module: picks pipes for the two slots and decides issue in order.
// Assumes decoded slots; the younger slot never issues without the older.
module duo_steer
    import duo_pkg::*;
(
    input  logic             v0,
    input  logic             v1,
    input  slot_dec_t        dec0,
    input  slot_dec_t        dec1,
    output logic             iss0,
    output logic             iss1,
    output logic [NPIPE-1:0] sel0,
    output logic [NPIPE-1:0] sel1,
    output logic [CNT_W-1:0] count
);
    localparam logic [NPIPE-1:0] M_A = NPIPE'(1) << P_A;
    localparam logic [NPIPE-1:0] M_B = NPIPE'(1) << P_B;

    logic [NPIPE-1:0] dst0, dst1, res0, res1;
    logic             pair_ok;

    duo_pair_rule u_pair (
        .grp0    (dec0.grp),
        .grp1    (dec1.grp),
        .pair_ok (pair_ok)
    );

    // Older slot: a flexible op leaves pipe A to a younger op that needs it.
    always_comb begin
        if (dec0.flex)
            dst0 = (v1 && dec1.fixed[P_A]) ? M_B : M_A;
        else
            dst0 = dec0.route;
        res0 = dec0.fixed | (dec0.flex ? dst0 : '0);
    end

    // Younger slot: a flexible op takes whichever integer pipe is left.
    always_comb begin
        if (dec1.flex)
            dst1 = res0[P_A] ? M_B : M_A;
        else
            dst1 = dec1.route;
        res1 = dec1.fixed | (dec1.flex ? dst1 : '0);
    end

    // Issue decision and masking of destinations for slots that stay.
    always_comb begin
        iss0  = v0 && !dec0.busy_hit;
        iss1  = iss0 && v1 && !dec1.busy_hit && !dec0.branch
                && pair_ok && ((res0 & res1) == '0);
        sel0  = iss0 ? dst0 : '0;
        sel1  = iss1 ? dst1 : '0;
        count = CNT_W'(iss0) + CNT_W'(iss1);
    end
endmodule

// File: rtl/duo_out_stage.sv
// Module: optional output register. REG_OUT=1 adds one clock of latency
// with synchronous active-low reset; REG_OUT=0 passes through.
module duo_out_stage #(
    parameter int W       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    if (REG_OUT) begin : g_reg
        // Capture the steering result, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= d;
        end
    end else begin : g_comb
        assign q = d;
    end
endmodule

// File: rtl/duo_issue_steer.sv
// Module: dual-issue pairing and steering top. Decodes both queue-head
// slots, applies pairing, exclusive-resource, branch and busy rules, and
// reports per-slot issue, one-hot destination and issue count.
// Assumes in0 is the older instruction and unit_busy is current.
module duo_issue_steer
    import duo_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in0_valid,
    input  logic [CLS_W-1:0] in0_class,
    input  logic             in1_valid,
    input  logic [CLS_W-1:0] in1_class,
    input  logic [NBUSY-1:0] unit_busy,
    output logic             issue0,
    output logic             issue1,
    output logic [NPIPE-1:0] pipe0_sel,
    output logic [NPIPE-1:0] pipe1_sel,
    output logic [CNT_W-1:0] issue_count
);
    localparam int OUT_W = 2 + 2 * NPIPE + CNT_W;

    logic [CLS_W-1:0] cls_a [NSLOT];
    slot_dec_t        dec_a [NSLOT];
    logic             iss0_c, iss1_c;
    logic [NPIPE-1:0] sel0_c, sel1_c;
    logic [CNT_W-1:0] cnt_c;
    logic [OUT_W-1:0] out_d, out_q;

    assign cls_a[0] = in0_class;
    assign cls_a[1] = in1_class;

    for (genvar s = 0; s < NSLOT; s++) begin : g_dec
        duo_slot_decode u_dec (
            .cls  (cls_a[s]),
            .busy (unit_busy),
            .dec  (dec_a[s])
        );
    end

    duo_steer u_steer (
        .v0    (in0_valid),
        .v1    (in1_valid),
        .dec0  (dec_a[0]),
        .dec1  (dec_a[1]),
        .iss0  (iss0_c),
        .iss1  (iss1_c),
        .sel0  (sel0_c),
        .sel1  (sel1_c),
        .count (cnt_c)
    );

    assign out_d = {iss0_c, iss1_c, sel0_c, sel1_c, cnt_c};

    duo_out_stage #(.W(OUT_W), .REG_OUT(REG_OUT)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (out_d),
        .q     (out_q)
    );

    assign {issue0, issue1, pipe0_sel, pipe1_sel, issue_count} = out_q;
endmodule

// File: rtl/duo_issue_steer_chk.sv
// Module: property checker for duo_issue_steer, bound to every instance.
// Holds the inputs for the output latency so rules relate in to out.
module duo_issue_steer_chk
    import duo_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in0_valid,
    input logic [CLS_W-1:0] in0_class,
    input logic             in1_valid,
    input logic [CLS_W-1:0] in1_class,
    input logic [NBUSY-1:0] unit_busy,
    input logic             issue0,
    input logic             issue1,
    input logic [NPIPE-1:0] pipe0_sel,
    input logic [NPIPE-1:0] pipe1_sel,
    input logic [CNT_W-1:0] issue_count
);
    logic             a_v0, a_v1;
    logic [CLS_W-1:0] a_c0, a_c1;
    logic [NBUSY-1:0] a_bz;

    if (REG_OUT) begin : g_lag
        // Align inputs with the registered outputs.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                a_v0 <= 1'b0; a_v1 <= 1'b0;
                a_c0 <= '0;   a_c1 <= '0;  a_bz <= '0;
            end else begin
                a_v0 <= in0_valid; a_v1 <= in1_valid;
                a_c0 <= in0_class; a_c1 <= in1_class; a_bz <= unit_busy;
            end
        end
    end else begin : g_now
        assign a_v0 = in0_valid;
        assign a_v1 = in1_valid;
        assign a_c0 = in0_class;
        assign a_c1 = in1_class;
        assign a_bz = unit_busy;
    end

    AST_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        issue1 |-> issue0); // R8

    AST_COUNT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        issue_count == CNT_W'($countones({issue0, issue1}))); // R10

    AST_SEL0_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        issue0 ? $onehot(pipe0_sel) : (pipe0_sel == '0)); // R10

    AST_SEL1_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        issue1 ? $onehot(pipe1_sel) : (pipe1_sel == '0)); // R10

    AST_NO_SHARED_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe0_sel & pipe1_sel) == '0); // R5

    AST_BRANCH_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (a_v0 && a_c0 == C_BRANCH) |-> !issue1); // R6

    AST_SOLO_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_v0 && a_c0 >= 4'd12) || (a_v1 && a_c1 >= 4'd12))
            |-> issue_count <= CNT_W'(1)); // R7

    AST_MD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (a_bz[BZ_MD] && a_c0 == C_MULDIV) |-> !issue0); // R9

    AST_OLDER_GOES: assert property (@(posedge clk) disable iff (!rst_n)
        (a_v0 && a_c0 == C_ALU) |-> issue0); // R1
endmodule

bind duo_issue_steer duo_issue_steer_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in0_valid   (in0_valid),
    .in0_class   (in0_class),
    .in1_valid   (in1_valid),
    .in1_class   (in1_class),
    .unit_busy   (unit_busy),
    .issue0      (issue0),
    .issue1      (issue1),
    .pipe0_sel   (pipe0_sel),
    .pipe1_sel   (pipe1_sel),
    .issue_count (issue_count)
);

// File: tb/duo_issue_steer_test.sv
// Bench: directed corner cases plus seeded random pairs, each compared
// against a reference model written from the requirements.
module duo_issue_steer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in0_valid = 1'b0, in1_valid = 1'b0;
    logic [3:0] in0_class = '0, in1_class = '0, unit_busy = '0;
    logic       issue0, issue1;
    logic [3:0] pipe0_sel, pipe1_sel;
    logic [1:0] issue_count;
    int         errors = 0, checks = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    duo_issue_steer uut (
        .clk(clk), .rst_n(rst_n),
        .in0_valid(in0_valid), .in0_class(in0_class),
        .in1_valid(in1_valid), .in1_class(in1_class),
        .unit_busy(unit_busy),
        .issue0(issue0), .issue1(issue1),
        .pipe0_sel(pipe0_sel), .pipe1_sel(pipe1_sel),
        .issue_count(issue_count)
    );

    // group: 0 int, 1 fp, 2 fp-mem, 3 alone
    function automatic int grp_of(logic [3:0] c);
        if (c >= 12) return 3;
        if (c == 4 || c == 5) return 2;
        if (c >= 9) return 1;
        return 0;
    endfunction

    // resources always used (bit0 A, bit1 B, bit2 FP, bit3 MEM)
    function automatic logic [3:0] need_of(logic [3:0] c);
        case (c)
            0: return 4'b0000;
            1, 6: return 4'b0001;
            2, 3, 4, 5: return 4'b1001;
            7, 8: return 4'b0010;
            9, 10, 11: return 4'b0100;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [3:0] dest_of(logic [3:0] c);
        case (c)
            1, 6, 12, 13, 14, 15: return 4'b0001;
            2, 3, 4, 5: return 4'b1000;
            7, 8: return 4'b0010;
            default: return 4'b0100;
        endcase
    endfunction

    function automatic bit blocked(logic [3:0] c, logic [3:0] b);
        return (c == 7 && b[0]) || (c == 10 && b[1]) || (c == 11 && b[2]) ||
               (c >= 2 && c <= 5 && b[3]);
    endfunction

    function automatic bit pair_legal(int g0, int g1);
        if (g0 == 0 && g1 == 0) return 1;
        if ((g0 == 0 && g1 == 1) || (g0 == 1 && g1 == 0)) return 1;
        if ((g0 == 1 && g1 == 2) || (g0 == 2 && g1 == 1)) return 1;
        return 0;
    endfunction

    // Returns {issue0, issue1, pipe0, pipe1, count}.
    function automatic logic [11:0] model(bit v0, logic [3:0] c0, bit v1,
                                          logic [3:0] c1, logic [3:0] b);
        logic [3:0] d0, d1, u0, u1;
        bit i0, i1;
        if (c0 == 0) d0 = (v1 && need_of(c1)[0]) ? 4'b0010 : 4'b0001;
        else         d0 = dest_of(c0);
        u0 = need_of(c0) | ((c0 == 0) ? d0 : 4'b0);
        if (c1 == 0) d1 = u0[0] ? 4'b0010 : 4'b0001;
        else         d1 = dest_of(c1);
        u1 = need_of(c1) | ((c1 == 0) ? d1 : 4'b0);
        i0 = v0 && !blocked(c0, b);
        i1 = i0 && v1 && !blocked(c1, b) && c0 != 8 &&
             pair_legal(grp_of(c0), grp_of(c1)) && ((u0 & u1) == 0);
        return {i0, i1, i0 ? d0 : 4'b0, i1 ? d1 : 4'b0, 2'(i0) + 2'(i1)};
    endfunction

    task automatic compare(string tag, logic [11:0] exp);
        logic [11:0] got;
        got = {issue0, issue1, pipe0_sel, pipe1_sel, issue_count};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%03h exp=%03h (c0=%0d c1=%0d busy=%b)",
                     tag, got, exp, in0_class, in1_class, unit_busy);
        end
    endtask

    // Drive at a falling edge, compare one clock later at the next one.
    task automatic apply(string tag, bit v0, logic [3:0] c0, bit v1,
                         logic [3:0] c1, logic [3:0] b);
        logic [11:0] exp;
        in0_valid = v0; in0_class = c0;
        in1_valid = v1; in1_class = c1; unit_busy = b;
        exp = model(v0, c0, v1, c1, b);
        @(negedge clk);
        compare(tag, exp);
    endtask

    initial begin
        // R11: reset clears outputs even with live inputs
        in0_valid = 1; in0_class = 0; in1_valid = 1; in1_class = 0;
        repeat (3) @(negedge clk);
        compare("R11 reset", 12'h000);
        rst_n = 1'b1;

        // R2 and R1: each class alone in slot 0
        for (int c = 0; c < 16; c++) apply("R2 route", 1, 4'(c), 0, 0, 0);
        apply("R1 older issues with younger blocked", 1, 0, 1, 7, 4'b0001);
        // R3 steering of the simple integer op
        apply("R3 alu+alu", 1, 0, 1, 0, 0);
        apply("R3 alu+shift", 1, 0, 1, 1, 0);
        apply("R3 alu+xfer", 1, 0, 1, 6, 0);
        apply("R3 load+alu", 1, 2, 1, 0, 0);
        apply("R3 alu+muldiv", 1, 0, 1, 7, 0);
        // R4 group pairing
        apply("R4 fadd+fload", 1, 9, 1, 4, 0);
        apply("R4 fstore+fmul", 1, 5, 1, 10, 0);
        apply("R4 load+fadd", 1, 2, 1, 9, 0);
        apply("R4 alu+fload rejected", 1, 0, 1, 4, 0);
        apply("R4 fload+alu rejected", 1, 4, 1, 0, 0);
        // R5 exclusive resources
        apply("R5 shift+shift", 1, 1, 1, 1, 0);
        apply("R5 load+store", 1, 2, 1, 3, 0);
        apply("R5 xfer+shift", 1, 6, 1, 1, 0);
        apply("R5 muldiv+branch", 1, 7, 1, 8, 0);
        apply("R5 fadd+fmul", 1, 9, 1, 10, 0);
        // R6 branch ends the group
        apply("R6 branch first", 1, 8, 1, 0, 0);
        apply("R6 branch second", 1, 0, 1, 8, 0);
        // R7 issue-alone classes
        apply("R7 alone older", 1, 12, 1, 0, 0);
        apply("R7 alone younger", 1, 0, 1, 15, 0);
        apply("R7 code 14 younger of fp", 1, 9, 1, 14, 0);
        // R8 in-order
        apply("R8 empty older", 0, 0, 1, 0, 0);
        apply("R8 blocked older", 1, 7, 1, 0, 4'b0001);
        // R9 busy flags
        apply("R9 fmul busy", 1, 10, 1, 0, 4'b0010);
        apply("R9 fdiv busy", 1, 11, 0, 0, 4'b0100);
        apply("R9 mem busy", 1, 3, 1, 0, 4'b1000);
        apply("R9 fload busy younger", 1, 9, 1, 4, 4'b1000);
        apply("R9 unrelated busy", 1, 0, 1, 0, 4'b1111);

        // R10 and R4/R5 mixed: seeded random pairs
        void'($urandom(32'h5eed));
        for (int n = 0; n < 3000; n++)
            apply("R10 random", ($urandom % 8) != 0, 4'($urandom),
                  ($urandom % 8) != 0, 4'($urandom),
                  4'($urandom & $urandom));
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hang counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule